// File: doc/BRIEF.md
# Carrier NCO with Serial Offset Tuning

The block is a numerically controlled oscillator that feeds the sine and cosine references of a digital downconversion mixer. Its tuning word is the sum, modulo 2^32, of two terms. The first is a center frequency written in parallel through a small register port. The second is an offset frequency shifted in one bit per clock over a serial pin pair. A control bit can force the offset term to zero without losing it.

On each enabled clock the tuning word is added to a 32-bit phase accumulator. The top 10 phase bits are added to a programmable 10-bit phase offset, and the result addresses a quarter-wave sine table. The table is mirrored to give full-cycle signed sine and cosine. The output frequency is the clock-enable rate times the tuning word divided by 2^32. Frequency changes never clear the accumulator, so the phase stays continuous when the carrier is retuned.

Top module: `carrier_nco`

## Requirements
- R1: While rst_ni is low, sin_o and cos_o are 0 and the accumulator is 0. After release, with ce_i low, the outputs show phase address 0.
- R2: A write with cfg_addr_i=0 loads the 32-bit center term from cfg_wdata_i. The new term is used from the next clock. The tuning word is center + offset, modulo 2^32.
- R3: ofs_data_i is shifted MSB first into a shadow register on every clock. ofs_sync_i is high together with the last (LSB) bit. The full shadow value becomes the active offset on the following clock. A partly shifted word never changes the tuning word.
- R4: A write with cfg_addr_i=1 sets the control word. When bit 16 is 1, the offset term is treated as zero. Clearing the bit restores the loaded offset.
- R5: The accumulator adds the tuning word only on clocks with ce_i=1. Otherwise it holds its value.
- R6: Bits [9:0] of the control word are a phase offset. It is added modulo 1024 to accumulator bits [31:22] to form the phase address a.
- R7: sin_o = round(A*sin(2*pi*(a+0.5)/1024)) with A=32767, rounding half away from zero. cos_o uses a+256. Both are registered one clock after the phase address.
- R8: Changing the center or offset term does not reset the accumulator. Phase continues from its current value.
- R9: The accumulator wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Accumulator advance enable |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | 0: center term, 1: control word |
| cfg_wdata_i | input | 32 | Register write data |
| ofs_data_i | input | 1 | Serial offset data, MSB first |
| ofs_sync_i | input | 1 | High with the last serial bit |
| sin_o | output | 16 | Signed sine sample |
| cos_o | output | 16 | Signed cosine sample |

## Verification
A table of vectors tries the oscillator with small tuning words, words that wrap the accumulator within a few steps, a center and offset pair whose sum wraps, and nonzero phase offsets in every quadrant. Together these separate adder, mirroring and sign faults. The offset term is set to values that only give correct phase when they are added, not ignored or swapped with the zeroing bit. Directed tests cover four cases: retuning mid-run, which shows phase continuity; ce_i held low; a half-shifted serial word that must not take effect; and setting and then clearing the zeroing bit.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam logic CFG_CENTER = 1'b0;
  localparam logic CFG_CTRL   = 1'b1;
  localparam int   CTRL_ZERO_BIT = 16;
  localparam real  NCO_PI = 3.14159265358979323846;
endpackage

// File: rtl/nco_offset_sr.sv
module nco_offset_sr #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         data_i,
  input  logic         sync_i,
  output logic [W-1:0] ofs_o
);
  logic [W-1:0] shadow_q;
  logic         sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      sync_q   <= 1'b0;
      ofs_o    <= '0;
    end else begin
      shadow_q <= {shadow_q[W-2:0], data_i};
      sync_q   <= sync_i;
      if (sync_q) ofs_o <= shadow_q;
    end
  end

  // R3
  ofs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_q |=> $stable(ofs_o));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic [ACC_W-1:0] tune_i,
  output logic [PH_W-1:0]  phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (ce_i) acc_q <= acc_q + tune_i;
  end

  assign phase_o = acc_q[ACC_W-1 -: PH_W];

  // R5
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(acc_q));
endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut #(
  parameter int AW    = 10,
  parameter int AMP_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);
  import nco_pkg::*;

  localparam int QW   = AW - 2;
  localparam int QN   = 1 << QW;
  localparam int FULL = 1 << AW;
  localparam int AMP  = (1 << (AMP_W - 1)) - 1;

  function automatic logic [AMP_W-1:0] quarter_val(input int q);
    real r;
    r = real'(AMP) * $sin(2.0 * NCO_PI * (real'(q) + 0.5) / real'(FULL));
    return AMP_W'($rtoi(r + 0.5));
  endfunction

  logic [AMP_W-1:0] qtab [QN];
  for (genvar g = 0; g < QN; g++) begin : g_tab
    assign qtab[g] = quarter_val(g);
  end

  logic signed [AMP_W-1:0] chan_val [2];
  // channel 0: sine, channel 1: cosine (quarter turn ahead)
  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic [AW-1:0]    a;
    logic [QW-1:0]    idx;
    logic [AMP_W-1:0] mag;
    always_comb begin
      a   = addr_i + AW'(c * (FULL / 4));
      idx = a[AW-2] ? ~a[QW-1:0] : a[QW-1:0];
      mag = qtab[idx];
      chan_val[c] = a[AW-1] ? -$signed(mag) : $signed(mag);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= chan_val[0];
      cos_o <= chan_val[1];
    end
  end

  // R7
  amp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_o <= AMP_W'(AMP)) && (sin_o >= -AMP_W'(AMP)) &&
    (cos_o <= AMP_W'(AMP)) && (cos_o >= -AMP_W'(AMP)));
endmodule

// File: rtl/carrier_nco.sv
module carrier_nco #(
  parameter int ACC_W  = 32,
  parameter int POFF_W = 10,
  parameter int AMP_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce_i,
  input  logic                    cfg_we_i,
  input  logic                    cfg_addr_i,
  input  logic [ACC_W-1:0]        cfg_wdata_i,
  input  logic                    ofs_data_i,
  input  logic                    ofs_sync_i,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);
  import nco_pkg::*;

  logic [ACC_W-1:0]  center_q;
  logic [POFF_W-1:0] poff_q;
  logic              zero_q;
  logic [ACC_W-1:0]  ofs_w;
  logic [ACC_W-1:0]  tune_w;
  logic [POFF_W-1:0] phase_w;
  logic [POFF_W-1:0] addr_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      center_q <= '0;
      poff_q   <= '0;
      zero_q   <= 1'b0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == CFG_CENTER) begin
        center_q <= cfg_wdata_i;
      end else begin
        poff_q <= cfg_wdata_i[POFF_W-1:0];
        zero_q <= cfg_wdata_i[CTRL_ZERO_BIT];
      end
    end
  end

  nco_offset_sr #(.W(ACC_W)) u_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (ofs_data_i),
    .sync_i (ofs_sync_i),
    .ofs_o  (ofs_w)
  );

  assign tune_w = center_q + (zero_q ? '0 : ofs_w);

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(POFF_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_i),
    .tune_i  (tune_w),
    .phase_o (phase_w)
  );

  assign addr_w = phase_w + poff_q;

  nco_sincos_lut #(.AW(POFF_W), .AMP_W(AMP_W)) u_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_w),
    .sin_o  (sin_o),
    .cos_o  (cos_o)
  );

  // R2
  center_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_addr_i == CFG_CENTER) |=> $stable(center_q));
  // R4
  zero_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_q |-> tune_w == center_q);
  // R6
  poff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_addr_i == CFG_CTRL) |=> $stable(poff_q));
endmodule

// File: tb/carrier_nco_tb.sv
module carrier_nco_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0, ce_i = 1'b0, cfg_we_i = 1'b0, cfg_addr_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic ofs_data_i = 1'b0, ofs_sync_i = 1'b0;
  logic signed [15:0] sin_o, cos_o;

  always #4 clk_i = ~clk_i;

  carrier_nco u_dut (.*);

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] m_acc, m_ctr, m_ofs, m_poff;
  logic m_zero;

  localparam int NV = 6;
  localparam logic [31:0] V_CTR  [NV] = '{32'h0040_0000, 32'h1234_5678, 32'hFFFF_FFFF,
                                         32'h4000_0000, 32'h0000_0000, 32'hC000_0001};
  localparam logic [31:0] V_OFS  [NV] = '{32'h0000_0000, 32'h0100_0000, 32'h0000_0002,
                                         32'h0C00_0000, 32'h8000_0000, 32'h4000_0000};
  localparam logic        V_ZERO [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [9:0]  V_POFF [NV] = '{10'd0, 10'd100, 10'd1023, 10'd300, 10'd700, 10'd513};
  localparam int          V_STEP [NV] = '{3, 5, 3, 7, 3, 4};

  function automatic logic signed [15:0] ref_wave(input logic [9:0] a);
    real r;
    r = 32767.0 * $sin(2.0 * 3.14159265358979323846 * (real'(a) + 0.5) / 1024.0);
    if (r >= 0.0) return 16'($rtoi(r + 0.5));
    return -16'($rtoi(-r + 0.5));
  endfunction

  function automatic logic [9:0] m_addr();
    return m_acc[31:22] + m_poff[9:0];
  endfunction

  task automatic chk(input string req, input logic signed [15:0] act, exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic chk_out(input string req);
    chk(req, sin_o, ref_wave(m_addr()));
    chk(req, cos_o, ref_wave(m_addr() + 10'd256));
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 1'b0;
    if (a) begin m_poff = {22'd0, d[9:0]}; m_zero = d[16]; end
    else m_ctr = d;
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = 31; i > 31 - n; i--) begin
      @(negedge clk_i); ofs_data_i = v[i]; ofs_sync_i = (i == 0);
    end
    @(negedge clk_i); ofs_data_i = 1'b0; ofs_sync_i = 1'b0;
  endtask

  task automatic load_ofs(input logic [31:0] v);
    shift_bits(v, 32);
    @(negedge clk_i);
    m_ofs = v;
  endtask

  task automatic step(input int n);
    @(negedge clk_i); ce_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      m_acc = m_acc + m_ctr + (m_zero ? 32'd0 : m_ofs);
      if (i < n - 1) @(negedge clk_i);
    end
    @(negedge clk_i); ce_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    m_acc = '0; m_ctr = '0; m_ofs = '0; m_poff = '0; m_zero = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    m_acc = '0; m_ctr = '0; m_ofs = '0; m_poff = '0; m_zero = 1'b0;
    // R1: reset state
    @(negedge clk_i);
    chk("R1", sin_o, 16'sd0);
    chk("R1", cos_o, 16'sd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk_out("R1");

    // table: R2 R4 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(1'b0, V_CTR[v]);
      load_ofs(V_OFS[v]);
      wr(1'b1, {15'd0, V_ZERO[v], 6'd0, V_POFF[v]});
      step(V_STEP[v]);
      chk_out("R7");
    end

    // R8: retune mid-run keeps phase
    do_reset();
    wr(1'b0, 32'h0100_0000);
    step(3);
    wr(1'b0, 32'h0300_0000);
    step(2);
    chk_out("R8");
    load_ofs(32'h0080_0000);
    step(2);
    chk_out("R8");

    // R5: ce low holds
    repeat (6) @(negedge clk_i);
    chk_out("R5");

    // R3: partial word has no effect
    shift_bits(32'hFFFF_FFFF, 16);
    step(2);
    chk_out("R3");
    load_ofs(32'h2000_0000);
    step(3);
    chk_out("R3");

    // R4: set then clear zeroing bit
    wr(1'b1, 32'h0001_0005);
    step(2);
    chk_out("R4");
    wr(1'b1, 32'h0000_0005);
    step(2);
    chk_out("R4");

    // R9: wrap with sum exceeding 2^32
    wr(1'b0, 32'hF000_0000);
    load_ofs(32'h2000_0000);
    step(5);
    chk_out("R9");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule